// File: doc/BRIEF.md
# Clock Loss Detector

This block guards a chip against a system clock that has stopped. A free-running reference clock, which does not depend on the system clock, times how long the monitored clock has stayed at one level. Each rising or falling transition of the monitored clock restarts that timer. If the monitored clock holds either level for longer than a configured window, the block raises a reset request in the reference-clock domain. Reset arbitration logic downstream consumes that request and records the missing clock as the cause. The request does not act on the external reset pin.

The monitored clock drives two toggle flops, one on each edge. Their XOR changes level on every transition. That level passes through a multi-stage synchroniser into the reference domain. An edge detector there turns each change into a one-cycle restart pulse for the timeout counter. Software sets an enable bit to 1 to arm the detector and sets it to 0 to disarm it. While the enable is 0 the block never requests reset, and raising the enable starts the count from zero. The window length in reference cycles is the window in microseconds multiplied by the reference frequency. With a 1 MHz reference and a 100 µs window the count is 100.

Top module: `clk_loss_detector`

## Requirements
- R1: While `ref_rst_n` is low, and on the first cycle after it is released, `clk_lost_req` is 0.
- R2: If every level of the monitored clock lasts at most TIMEOUT reference cycles, `clk_lost_req` stays 0. TIMEOUT is ceil(REF_FREQ_KHZ × WINDOW_US / 1000).
- R3: If the monitored clock stops low, `clk_lost_req` rises after exactly TIMEOUT + SYNC_STAGES + 1 reference rising edges. Those edges are counted from the last transition, for a transition placed between two reference edges. A level lasting TIMEOUT + 1 reference cycles is enough to raise the request.
- R4: If the monitored clock stops high, the request rises with the same timing as in R3.
- R5: While the monitored clock stays stopped and the enable stays 1, the request stays 1. The internal count never passes TIMEOUT.
- R6: Once the request is 1, a new monitored-clock transition clears it after SYNC_STAGES + 1 reference rising edges. The request is still 1 after SYNC_STAGES edges.
- R7: While `det_en` is 0, `clk_lost_req` is 0. Dropping `det_en` removes an active request in the same cycle, without waiting for a clock edge.
- R8: Raising `det_en` restarts the count from zero. With the monitored clock stopped, the request stays 0 for TIMEOUT reference rising edges after the rise and becomes 1 after edge TIMEOUT + 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Free-running reference clock, independent of the monitored clock |
| ref_rst_n | input | 1 | Active-low asynchronous reset for all detector state |
| mon_clk | input | 1 | Clock being watched |
| det_en | input | 1 | 1 arms the detector, 0 disarms it (reference domain) |
| clk_lost_req | output | 1 | Reset request, 1 while the monitored clock is considered lost |

## Verification
The bench builds the block with REF_FREQ_KHZ = 1000, WINDOW_US = 16 and SYNC_STAGES = 2. This gives a 16-cycle window and a 3-cycle transition latency. With a window that short, the exact rise cycle of the request for a clock stuck low and for a clock stuck high can be sampled directly. The length of a single level can also be placed exactly at TIMEOUT and at TIMEOUT + 1 cycles, and this pair is the boundary between silence and a request. The enable is placed on reference falling edges, so the restart on enable and the immediate drop of the request on disable can each be checked at a known cycle.

// File: rtl/mcd_pkg.sv
package mcd_pkg;

  // Reference cycles covering the window, rounded up.
  function automatic int timeout_cycles(input int ref_khz, input int window_us);
    return (ref_khz * window_us + 999) / 1000;
  endfunction

  // Bits needed to hold 0..limit.
  function automatic int cnt_width(input int limit);
    return (limit < 1) ? 1 : $clog2(limit + 1);
  endfunction

endpackage

// File: rtl/mcd_transition_tog.sv
module mcd_transition_tog (
  input  logic mon_clk,
  input  logic rst_n,
  output logic tog_o
);
  logic rise_t;
  logic fall_t;

  always_ff @(posedge mon_clk or negedge rst_n) begin
    if (!rst_n) rise_t <= 1'b0;
    else        rise_t <= ~rise_t;
  end

  always_ff @(negedge mon_clk or negedge rst_n) begin
    if (!rst_n) fall_t <= 1'b0;
    else        fall_t <= ~fall_t;
  end

  // Only one flop changes per transition, so the XOR flips once per edge.
  assign tog_o = rise_t ^ fall_t;
endmodule

// File: rtl/mcd_sync.sv
module mcd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr[0] <= 1'b0;
        else        sr[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr[g] <= 1'b0;
        else        sr[g] <= sr[g-1];
      end
    end
  end

  assign q_o = sr[STAGES-1];
endmodule

// File: rtl/mcd_edge_det.sv
module mcd_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic edge_o
);
  logic lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl_i;
  end

  assign edge_o = lvl_i ^ lvl_q;
endmodule

// File: rtl/mcd_timeout_ctr.sv
module mcd_timeout_ctr #(
  parameter int TIMEOUT = 100,
  parameter int CNT_W   = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable_i,
  input  logic restart_i,
  output logic expired_o
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT);

  logic [CNT_W-1:0] cnt;
  logic             en_q;
  logic             en_rise;
  logic             clear;
  logic             at_limit;

  assign en_rise  = enable_i & ~en_q;
  assign clear    = restart_i | ~enable_i | en_rise;
  assign at_limit = (cnt == LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= enable_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (clear)     cnt <= '0;
    else if (!at_limit) cnt <= cnt + 1'b1;
  end

  assign expired_o = enable_i & at_limit;

  // R5: saturating count
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LIMIT);

  // R6: a transition restarts the count
  p_edge_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (cnt == '0));

  // R8: enabling restarts the count
  p_en_rise_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(enable_i) |=> (cnt == '0));

  // R5: a full count holds without a restart
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (at_limit && enable_i && en_q && !restart_i) |=> at_limit);

  // R3: count only advances by one from its previous value
  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0 && !at_limit) |-> (32'(cnt) == 32'($past(cnt)) + 1));
endmodule

// File: rtl/clk_loss_detector.sv
module clk_loss_detector #(
  parameter int REF_FREQ_KHZ = 1000,
  parameter int WINDOW_US    = 100,
  parameter int SYNC_STAGES  = 2
) (
  input  logic ref_clk,
  input  logic ref_rst_n,
  input  logic mon_clk,
  input  logic det_en,
  output logic clk_lost_req
);
  localparam int TIMEOUT = mcd_pkg::timeout_cycles(REF_FREQ_KHZ, WINDOW_US);
  localparam int CNT_W   = mcd_pkg::cnt_width(TIMEOUT);

  logic mon_tog;
  logic tog_ref;
  logic mon_edge_seen;

  mcd_transition_tog u_tog (
    .mon_clk (mon_clk),
    .rst_n   (ref_rst_n),
    .tog_o   (mon_tog)
  );

  mcd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (ref_clk),
    .rst_n (ref_rst_n),
    .d_i   (mon_tog),
    .q_o   (tog_ref)
  );

  mcd_edge_det u_edge (
    .clk    (ref_clk),
    .rst_n  (ref_rst_n),
    .lvl_i  (tog_ref),
    .edge_o (mon_edge_seen)
  );

  mcd_timeout_ctr #(.TIMEOUT(TIMEOUT), .CNT_W(CNT_W)) u_ctr (
    .clk       (ref_clk),
    .rst_n     (ref_rst_n),
    .enable_i  (det_en),
    .restart_i (mon_edge_seen),
    .expired_o (clk_lost_req)
  );

  // R3: a request only starts after a cycle with no transition seen
  p_quiet_before_req_r3: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    $rose(clk_lost_req) |-> $past(!mon_edge_seen));
endmodule

// File: tb/clk_loss_detector_tb.sv
module clk_loss_detector_tb_top;
  localparam int KHZ   = 1000;
  localparam int WIN   = 16;
  localparam int SYNC  = 2;
  localparam int T_CYC = (KHZ * WIN + 999) / 1000;
  localparam int LAT   = SYNC + 1;

  logic ref_clk = 1'b0;
  logic ref_rst_n = 1'b0;
  logic mon_clk = 1'b0;
  logic det_en = 1'b1;
  logic clk_lost_req;

  int n_chk = 0;
  int n_fail = 0;

  always #4 ref_clk = ~ref_clk;

  clk_loss_detector #(.REF_FREQ_KHZ(KHZ), .WINDOW_US(WIN), .SYNC_STAGES(SYNC)) dut_i (
    .ref_clk      (ref_clk),
    .ref_rst_n    (ref_rst_n),
    .mon_clk      (mon_clk),
    .det_en       (det_en),
    .clk_lost_req (clk_lost_req)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge ref_clk);
  endtask

  // Steps n cycles; returns how many samples saw the request high.
  task automatic step_count(input int n, output int hits);
    hits = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge ref_clk);
      if (clk_lost_req === 1'b1) hits++;
    end
  endtask

  task automatic t_reset;
    chk("R1 during reset", clk_lost_req, 1'b0);
    ref_rst_n = 1'b1;
    step(1);
    chk("R1 after release", clk_lost_req, 1'b0);
  endtask

  task automatic t_running;
    int hits;
    int total;
    total = 0;
    for (int i = 0; i < 40; i++) begin
      mon_clk = ~mon_clk;
      step_count(5, hits);
      total += hits;
    end
    chk("R2 fast clock no request", total != 0, 1'b0);
  endtask

  task automatic t_level_boundary;
    int hits;
    int total;
    mon_clk = ~mon_clk;
    step(LAT);
    total = 0;
    for (int i = 0; i < 6; i++) begin
      mon_clk = ~mon_clk;
      step_count(T_CYC, hits);
      total += hits;
    end
    chk("R2 levels of TIMEOUT cycles", total != 0, 1'b0);
    total = 0;
    for (int i = 0; i < 5; i++) begin
      mon_clk = ~mon_clk;
      step_count(T_CYC + 1, hits);
      total += hits;
    end
    chk("R3 levels of TIMEOUT+1 cycles fire", total != 0, 1'b1);
  endtask

  task automatic t_stuck(input logic lvl, input string tag);
    int hits;
    if (mon_clk == lvl) begin
      mon_clk = ~lvl;
      step(1);
    end
    mon_clk = lvl;
    step(T_CYC + LAT - 1);
    chk({tag, " quiet before window"}, clk_lost_req, 1'b0);
    step(1);
    chk({tag, " request at window"}, clk_lost_req, 1'b1);
    step_count(2 * T_CYC, hits);
    chk("R5 request held while stopped", hits == 2 * T_CYC, 1'b1);
  endtask

  task automatic t_restart;
    mon_clk = ~mon_clk;
    step(LAT - 1);
    chk("R6 still high before latency", clk_lost_req, 1'b1);
    step(1);
    chk("R6 cleared by transition", clk_lost_req, 1'b0);
  endtask

  task automatic t_enable;
    int hits;
    step(T_CYC + LAT + 1);
    chk("R7 precondition request active", clk_lost_req, 1'b1);
    det_en = 1'b0;
    #1;
    chk("R7 disable drops request at once", clk_lost_req, 1'b0);
    step_count(3 * T_CYC, hits);
    chk("R7 no request while disabled", hits != 0, 1'b0);
    det_en = 1'b1;
    step(T_CYC);
    chk("R8 count restarted on enable", clk_lost_req, 1'b0);
    step(1);
    chk("R8 request after full window", clk_lost_req, 1'b1);
  endtask

  initial begin
    #(8 * 20000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: got hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    step(4);
    t_reset();
    t_running();
    t_level_boundary();
    t_stuck(1'b0, "R3");
    t_restart();
    t_stuck(1'b1, "R4");
    t_restart();
    t_enable();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule